// File: doc/BRIEF.md
# Signed Array Multiply-Accumulate Unit

This block multiplies two signed two's complement operands in a purely combinational array built from one explicit cell per partial-product bit. It adds the double-width product into an accumulator register on clock edges where accumulation is enabled. The array never uses a behavioural multiply. Every wire inside it carries a known sign of weight, either added or subtracted. Each adder cell is one of four generalized full-adder variants, picked at elaboration from the weights of the bits that reach it. Sign bits are therefore handled where they arise, and no correction constant is added afterwards.

The product is also visible on its own output for testing. The accumulator adds the sign-extended product through a ripple-carry chain of the same cells. It wraps silently on overflow. A synchronous reset or clear empties it, and either one overrides an accumulate request in the same cycle.

Top module: `signed_mac`

## Requirements
- R1: `prod_q` equals the signed product of `op_a` and `op_b` as a 16-bit two's complement value, for every one of the 65536 operand pairs, without waiting for a clock edge.
- R2: The pair -128 × -128 (both operands 8'h80) yields exactly 16'h4000 on `prod_q`. No carry is ever lost beyond bit 15 of the array.
- R3: With `rst` high at a rising edge, `acc_q` is 16'h0000 after that edge, whatever `acc_en` and `clr` are.
- R4: With `acc_en` high and `clr`, `rst` low at a rising edge, `acc_q` becomes its previous value plus the sign-extended product of the operands present at that edge.
- R5: With `clr` high at a rising edge, `acc_q` becomes 16'h0000, even when `acc_en` is also high.
- R6: With `acc_en` and `clr` both low, `acc_q` keeps its value across edges however the operands change.
- R7: Accumulation is modulo 2^16. A sum past +32767 or below -32768 wraps with no saturation, for example three loads of 127 × 127 give 16'hBD03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, clears the accumulator |
| acc_en | input | 1 | Adds the current product into the accumulator at the edge |
| clr | input | 1 | Synchronous clear of the accumulator, overrides `acc_en` |
| op_a | input | 8 | Multiplicand, signed two's complement |
| op_b | input | 8 | Multiplier, signed two's complement |
| acc_q | output | 16 | Accumulator value, signed two's complement |
| prod_q | output | 16 | Combinational product of the current operands |

## Verification
A cell with the wrong weight variant, or a sum routed to the wrong column, corrupts `prod_q` at once. It does so only for the operand pairs that drive that cell, and often only those with a sign bit set, so the product is swept over all pairs rather than sampled. A fault in the accumulator chain or its control shows on `acc_q` one edge after the affected load, clear or hold. The wrong value is then carried into every later sum, so the error stays visible until the next clear.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

  localparam int MAC_W     = 8;
  localparam int MAC_ACC_W = 16;

  // Weight mask {x, y, z} of array cell at row i (multiplier bit), column j
  // (multiplicand bit); a set bit marks a subtracted (negative-weight) input.
  // x = local AND term, y = sum from the row above, z = carry from the row above.
  function automatic logic [2:0] arr_neg(input int i, input int j, input int w);
    logic t_neg;
    logic s_neg;
    t_neg = ((i == w - 1) != (j == w - 1));
    s_neg = (j < w - 1) && (j >= w - 1 - i);
    return {t_neg, s_neg, 1'b0};
  endfunction

  // Weight mask {x, y, z} of final ripple stage at product weight k:
  // x = leftover row sum (positive), y = last-row carry (negative except at
  // the top), z = ripple carry (negative; the constant zero at k == w is
  // taken as negative as well).
  function automatic logic [2:0] rip_neg(input int k, input int w);
    return (k == 2 * w - 1) ? 3'b001 : 3'b011;
  endfunction

endpackage

// File: rtl/mac_wcell.sv
`timescale 1ns/1ps
// Generalized full adder. Inputs marked in NEG count with negative weight.
// With n negative inputs the outputs are: n=0 sum+,carry+; n=1 sum-,carry+;
// n=2 sum+,carry-; n=3 sum-,carry-.
module mac_wcell #(
  parameter logic [2:0] NEG = 3'b000
) (
  input  logic x,
  input  logic y,
  input  logic z,
  output logic s,
  output logic co
);
  localparam int   NNEG    = int'(NEG[0]) + int'(NEG[1]) + int'(NEG[2]);
  localparam logic S_FLIP  = (NNEG == 1) || (NNEG == 3);
  localparam logic CO_FLIP = (NNEG >= 2);

  logic ux, uy, uz, fs, fc;

  assign ux = x ^ NEG[2];
  assign uy = y ^ NEG[1];
  assign uz = z ^ NEG[0];
  assign fs = ux ^ uy ^ uz;
  assign fc = (ux & uy) | (uz & (ux ^ uy));
  assign s  = fs ^ S_FLIP;
  assign co = fc ^ CO_FLIP;
endmodule

// File: rtl/mac_array_mult.sv
`timescale 1ns/1ps
module mac_array_mult #(
  parameter int W = mac_pkg::MAC_W
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p,
  output logic           top_carry
);
  localparam int PW = 2 * W;

  wire [W-1:0]  s_row [W];
  wire [W-1:0]  c_row [W];
  wire [PW:W]   rc;
  wire [PW-1:0] pw;

  genvar i, j, k;

  // Row 0: AND-only cells, no addition.
  for (j = 0; j < W; j++) begin : g_r0
    assign s_row[0][j] = a[j] & b[0];
    assign c_row[0][j] = 1'b0;
  end

  // Rows 1..W-1: carry-save rows of weighted full adders.
  for (i = 1; i < W; i++) begin : g_row
    for (j = 0; j < W; j++) begin : g_col
      localparam logic [2:0] NEG = mac_pkg::arr_neg(i, j, W);
      if (j == W - 1) begin : g_edge
        mac_wcell #(.NEG(NEG)) u_cell (
          .x (a[j] & b[i]),
          .y (1'b0),
          .z (c_row[i-1][j]),
          .s (s_row[i][j]),
          .co(c_row[i][j])
        );
      end else begin : g_mid
        mac_wcell #(.NEG(NEG)) u_cell (
          .x (a[j] & b[i]),
          .y (s_row[i-1][j+1]),
          .z (c_row[i-1][j]),
          .s (s_row[i][j]),
          .co(c_row[i][j])
        );
      end
    end
  end

  // Low product bits leave the array at column 0 of each row.
  for (i = 0; i < W; i++) begin : g_low
    assign pw[i] = s_row[i][0];
  end

  // High product bits: ripple merge of last-row sums and carries.
  assign rc[W] = 1'b0;
  for (k = W; k < PW; k++) begin : g_fin
    localparam logic [2:0] NEG = mac_pkg::rip_neg(k, W);
    if (k == PW - 1) begin : g_msb
      mac_wcell #(.NEG(NEG)) u_cell (
        .x (1'b0),
        .y (c_row[W-1][k-W]),
        .z (rc[k]),
        .s (pw[k]),
        .co(rc[k+1])
      );
    end else begin : g_mid
      mac_wcell #(.NEG(NEG)) u_cell (
        .x (s_row[W-1][k-W+1]),
        .y (c_row[W-1][k-W]),
        .z (rc[k]),
        .s (pw[k]),
        .co(rc[k+1])
      );
    end
  end

  assign p         = pw;
  assign top_carry = rc[PW];
endmodule

// File: rtl/mac_accum.sv
`timescale 1ns/1ps
module mac_accum #(
  parameter int ACC_W = mac_pkg::MAC_ACC_W
) (
  input  logic             clk,
  input  logic             zero,
  input  logic             load,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc_q,
  output logic             cout
);
  logic [ACC_W-1:0] acc_r;
  wire  [ACC_W-1:0] sum;
  wire  [ACC_W:0]   ch;

  assign ch[0] = 1'b0;

  genvar k;
  for (k = 0; k < ACC_W; k++) begin : g_rip
    mac_wcell #(.NEG(3'b000)) u_cell (
      .x (acc_r[k]),
      .y (addend[k]),
      .z (ch[k]),
      .s (sum[k]),
      .co(ch[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (zero)      acc_r <= '0;
    else if (load) acc_r <= sum;
  end

  assign acc_q = acc_r;
  assign cout  = ch[ACC_W];
endmodule

// File: rtl/signed_mac.sv
`timescale 1ns/1ps
module signed_mac #(
  parameter int W     = mac_pkg::MAC_W,
  parameter int ACC_W = mac_pkg::MAC_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_en,
  input  logic             clr,
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  output logic [ACC_W-1:0] acc_q,
  output logic [2*W-1:0]   prod_q
);
  localparam int PW = 2 * W;

  // Named internal events, observed by the bound checker.
  logic [PW-1:0]    prod_w;
  logic [ACC_W-1:0] ext_prod;
  logic             prod_cout;
  logic             acc_cout;
  logic             acc_zero;
  logic             acc_load;

  mac_array_mult #(.W(W)) u_mult (
    .a        (op_a),
    .b        (op_b),
    .p        (prod_w),
    .top_carry(prod_cout)
  );

  assign ext_prod = ACC_W'($signed(prod_w));
  assign acc_zero = rst | clr;
  assign acc_load = acc_en & ~acc_zero;

  mac_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .zero  (acc_zero),
    .load  (acc_load),
    .addend(ext_prod),
    .acc_q (acc_q),
    .cout  (acc_cout)
  );

  assign prod_q = prod_w;
endmodule

// File: rtl/mac_checker.sv
`timescale 1ns/1ps
module mac_checker #(
  parameter int W     = mac_pkg::MAC_W,
  parameter int ACC_W = mac_pkg::MAC_ACC_W
) (
  input logic             clk,
  input logic             rst,
  input logic             acc_en,
  input logic             clr,
  input logic [W-1:0]     op_a,
  input logic [W-1:0]     op_b,
  input logic [ACC_W-1:0] acc_q,
  input logic [2*W-1:0]   prod_q,
  input logic [ACC_W-1:0] ext_prod,
  input logic             prod_cout,
  input logic             acc_cout,
  input logic             acc_zero,
  input logic             acc_load
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [PW-1:0] CORNER_P = PW'(1) << (PW - 2);

  logic [PW-1:0]  beh_prod;
  logic [ACC_W:0] wide_sum;

  assign beh_prod = PW'(int'($signed(op_a)) * int'($signed(op_b)));
  assign wide_sum = {1'b0, acc_q} + {1'b0, ext_prod};

  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    prod_q == beh_prod);

  assert_corner_R2: assert property (@(posedge clk) disable iff (rst)
    (op_a == MOST_NEG && op_b == MOST_NEG) |-> prod_q == CORNER_P);

  assert_no_carry_R2: assert property (@(posedge clk) disable iff (rst)
    prod_cout == 1'b0);

  assert_reset_R3: assert property (@(posedge clk)
    rst |=> acc_q == '0);

  assert_accum_R4: assert property (@(posedge clk) disable iff (rst)
    acc_load |=> acc_q == $past(acc_q) + $past(ext_prod));

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && acc_en) |=> acc_q == '0);

  assert_zero_R5: assert property (@(posedge clk)
    acc_zero |=> acc_q == '0);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !clr) |=> $stable(acc_q));

  assert_carry_R7: assert property (@(posedge clk) disable iff (rst)
    acc_cout == wide_sum[ACC_W]);
endmodule

bind signed_mac mac_checker #(.W(W), .ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .acc_en   (acc_en),
  .clr      (clr),
  .op_a     (op_a),
  .op_b     (op_b),
  .acc_q    (acc_q),
  .prod_q   (prod_q),
  .ext_prod (ext_prod),
  .prod_cout(prod_cout),
  .acc_cout (acc_cout),
  .acc_zero (acc_zero),
  .acc_load (acc_load)
);

// File: tb/tb_signed_mac.sv
`timescale 1ns/1ps
module tb_signed_mac;
  logic        clk = 1'b0;
  logic        rst, acc_en, clr;
  logic [7:0]  op_a, op_b;
  logic [15:0] acc_q, prod_q;
  logic [15:0] model;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  signed_mac dut (
    .clk(clk), .rst(rst), .acc_en(acc_en), .clr(clr),
    .op_a(op_a), .op_b(op_b), .acc_q(acc_q), .prod_q(prod_q)
  );

  function automatic logic [15:0] exp_prod(input logic [7:0] x, input logic [7:0] y);
    int p;
    p = int'($signed(x)) * int'($signed(y));
    return p[15:0];
  endfunction

  function automatic logic [15:0] exp_acc(input logic [15:0] acc, input logic [7:0] x,
                                          input logic [7:0] y);
    int s;
    s = int'($signed(acc)) + int'($signed(exp_prod(x, y)));
    return s[15:0];
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One clocked step; acc_q is sampled 1 ns after the edge.
  task automatic step(input logic en, input logic c, input logic [7:0] x, input logic [7:0] y);
    @(negedge clk);
    acc_en = en; clr = c; op_a = x; op_b = y;
    @(posedge clk);
    #1;
    if (c)       model = 16'h0000;
    else if (en) model = exp_acc(model, x, y);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog (all requirements) got=timeout exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; acc_en = 1'b1; clr = 1'b0; op_a = 8'd3; op_b = 8'd4;
    model = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    check("R3 reset with acc_en high", acc_q, 16'h0000);
    @(negedge clk);
    rst = 1'b0; acc_en = 1'b0;

    // Directed product corners
    op_a = 8'h80; op_b = 8'h80; #1;
    check("R2 -128*-128", prod_q, 16'h4000);
    op_a = 8'h7F; op_b = 8'h80; #1;
    check("R1 127*-128", prod_q, 16'hC080);
    op_a = 8'h7F; op_b = 8'h7F; #1;
    check("R1 127*127", prod_q, 16'h3F01);
    op_a = 8'hFF; op_b = 8'hFF; #1;
    check("R1 -1*-1", prod_q, 16'h0001);

    // Load a nonzero value, then sweep all operand pairs with no load
    step(1'b1, 1'b0, 8'd5, 8'hFD);
    check("R4 5*-3", acc_q, 16'hFFF1);
    step(1'b0, 1'b0, 8'd0, 8'd0);
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        op_a = x[7:0]; op_b = y[7:0];
        #1;
        check("R1 sweep", prod_q, exp_prod(x[7:0], y[7:0]));
      end
    end
    @(posedge clk); #1;
    check("R6 hold across operand sweep", acc_q, 16'hFFF1);

    // Accumulation patterns
    step(1'b1, 1'b0, 8'h80, 8'h7F);
    check("R4 add negative", acc_q, model);
    step(1'b1, 1'b0, 8'h80, 8'h80);
    check("R4 add corner", acc_q, model);
    step(1'b0, 1'b0, 8'h11, 8'h22);
    check("R6 hold", acc_q, model);

    // Clear has priority over accumulate
    step(1'b1, 1'b1, 8'h40, 8'h40);
    check("R5 clear over acc_en", acc_q, 16'h0000);

    // Wrap past +32767
    step(1'b1, 1'b0, 8'h7F, 8'h7F);
    step(1'b1, 1'b0, 8'h7F, 8'h7F);
    check("R7 pre-wrap", acc_q, 16'h7E02);
    step(1'b1, 1'b0, 8'h7F, 8'h7F);
    check("R7 wrap positive", acc_q, 16'hBD03);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    step(1'b1, 1'b0, 8'h80, 8'h80);
    step(1'b1, 1'b0, 8'h80, 8'h80);
    check("R7 wrap to 0x8000", acc_q, 16'h8000);
    step(1'b1, 1'b1, 8'h00, 8'h00);
    step(1'b1, 1'b0, 8'h80, 8'h7F);
    step(1'b1, 1'b0, 8'h80, 8'h7F);
    step(1'b1, 1'b0, 8'h80, 8'h7F);
    check("R7 wrap negative", acc_q, model);

    // Mid-run reset overrides accumulate
    @(negedge clk);
    rst = 1'b1; acc_en = 1'b1; op_a = 8'h33; op_b = 8'h44;
    @(posedge clk); #1;
    model = 16'h0000;
    check("R3 mid-run reset", acc_q, 16'h0000);
    @(negedge clk);
    rst = 1'b0; acc_en = 1'b0;

    // Constrained random enable / clear sequence
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom();
      step((r[1:0] != 2'b00), (r[5:2] == 4'h0), r[15:8], r[23:16]);
      check("R4 random sequence", acc_q, model);
      check("R1 random product", prod_q, exp_prod(r[15:8], r[23:16]));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule